// File: doc/BRIEF.md
# Stepper Motor Phase Pattern Generator

This block turns single-cycle step strobes and a direction bit into the four coil drive lines of a four-phase stepper motor. It keeps a position counter within an eight-position cycle. A mode input chooses how that position is shown on the coils: a single coil, an adjacent pair of coils, or half-stepping, which alternates single and pair states. Step timing, step counting and the power stage belong to the neighbouring logic.

After reset the coils stay off until the first accepted step. That step drives a fixed reference position, which depends on the direction. It raises a one-cycle flag so that an external step counter can leave it out of its count. When the run input is low, a select input either forces all coils to zero or keeps the pattern energized. Changing the mode while the motor is stopped moves the position to the nearest position that the new mode can show.

Top module: `stepper_phase_gen`

## Requirements
- R1: While reset is asserted and directly after it, `coil_o` is 0000 and `ref_step_o` is 0.
- R2: The first step accepted after reset with `dir_i`=1 (clockwise) lights coil 0 (`coil_o` 0001 in single-coil mode). It sets `ref_step_o` to 1 for the cycle that follows the sampling edge.
- R3: The first step accepted after reset with `dir_i`=0 (counter-clockwise) lights coil 3 (`coil_o` 1000 in single-coil mode).
- R4: With `mode_i`=0 (or 3), single-coil mode, each clockwise step moves through 0001, 0010, 0100, 1000 and wraps back to 0001. Counter-clockwise steps run the same cycle in reverse.
- R5: With `mode_i`=1, coil-pair mode, clockwise steps move through 0011, 0110, 1100, 1001 and wrap. Exactly two coils are on while running.
- R6: With `mode_i`=2, half-step mode, clockwise steps move through the eight states 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001 and wrap. Counter-clockwise steps run them in reverse.
- R7: `ref_step_o` goes high only for the first accepted step after reset, and then for exactly one cycle.
- R8: While `run_i`=0, `coil_o` is 0000 if `hold_i`=0. It shows the current pattern if `hold_i`=1.
- R9: A step strobe while `run_i`=0 does not change the position. The next step after `run_i` returns to 1 moves from the position held before the stop.
- R10: When the mode changes, the position moves to the nearest valid position of the new mode. Going to single-coil mode drops a pair state to its lower-numbered coil. Going to coil-pair mode turns a single state into the pair made of that coil and the next one up.
- R11: Reset clears the record of the first step, so the next accepted step again drives the reference position and raises `ref_step_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Single-cycle step strobe |
| dir_i | input | 1 | 1 = clockwise, 0 = counter-clockwise |
| mode_i | input | 2 | 0/3 single coil, 1 coil pair, 2 half-step |
| hold_i | input | 1 | 1 = keep the pattern while stopped, 0 = coils off |
| run_i | input | 1 | Motor running; steps are accepted only while high |
| coil_o | output | 4 | Coil drive lines, bit n drives coil n |
| ref_step_o | output | 1 | One-cycle flag for the reference step |

## Verification
The step sequence runs in each mode in both directions and carries on past the wrap point, which tells an increment apart from a decrement and a correct modulus from a wrong one. Mode switches happen both during a run and while stopped with hold selected, so the rounding of odd and even positions shows up on the coils. The first step is tried clockwise, then again counter-clockwise after a second reset. This separates the two reference coils and shows that reset clears the first-step history. A step given while stopped is followed by a resumed step, which shows whether the stopped step moved the position.

// File: rtl/stepper_phase_gen.sv
module stepper_phase_gen #(
  parameter int NCOIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic             hold_i,
  input  logic             run_i,
  output logic [NCOIL-1:0] coil_o,
  output logic             ref_step_o
);
  localparam int NPOS = 2 * NCOIL;
  localparam int IW   = $clog2(NPOS);
  localparam int BW   = IW - 1;
  localparam logic [IW-1:0] CCW_REF = IW'(NPOS - 2);

  logic [IW-1:0]    pos_q, pos_n, pos_step;
  logic [IW-1:0]    delta;
  logic [BW-1:0]    base, nxt;
  logic             started_q;
  logic [NCOIL-1:0] pat;

  function automatic logic [IW-1:0] snap(input logic [IW-1:0] p, input logic [1:0] m);
    case (m)
      2'd1:    snap = {p[IW-1:1], 1'b1};
      2'd2:    snap = p;
      default: snap = {p[IW-1:1], 1'b0};
    endcase
  endfunction

  assign pos_n    = snap(pos_q, mode_i);
  assign delta    = (mode_i == 2'd2) ? IW'(1) : IW'(2);
  assign pos_step = dir_i ? pos_n + delta : pos_n - delta;
  assign base     = pos_n[IW-1:1];
  assign nxt      = base + BW'(1);

  always_comb begin
    for (int i = 0; i < NCOIL; i++)
      pat[i] = (BW'(i) == base) || (pos_n[0] && (BW'(i) == nxt));
  end

  assign coil_o = (started_q && (run_i || hold_i)) ? pat : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      started_q  <= 1'b0;
      ref_step_o <= 1'b0;
    end else begin
      ref_step_o <= 1'b0;
      if (run_i && step_i) begin
        if (!started_q) begin
          started_q  <= 1'b1;
          ref_step_o <= 1'b1;
          pos_q      <= snap(dir_i ? '0 : CCW_REF, mode_i);
        end else begin
          pos_q <= pos_step;
        end
      end else begin
        pos_q <= pos_n;
      end
    end
  end
endmodule

// File: rtl/stepper_phase_gen_chk.sv
module stepper_phase_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_i,
  input logic [1:0] mode_i,
  input logic       hold_i,
  input logic       run_i,
  input logic [3:0] coil_o,
  input logic       ref_step_o
);
  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step_o |=> !ref_step_o); // R7
  AST_REF_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step_o |-> $past(step_i && run_i)); // R7
  AST_SINGLE_COIL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (mode_i == 2'd0 || mode_i == 2'd3)) |-> $onehot0(coil_o)); // R4
  AST_PAIR_COILS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mode_i == 2'd1 && coil_o != 4'd0) |-> $countones(coil_o) == 2); // R5
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !hold_i) |-> coil_o == 4'd0); // R8
  AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step_i) && run_i && $past(run_i) && $past(mode_i) == mode_i
     && $past(coil_o) != 4'd0) |-> $stable(coil_o)); // R9
endmodule

bind stepper_phase_gen stepper_phase_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i),
  .hold_i(hold_i), .run_i(run_i), .coil_o(coil_o), .ref_step_o(ref_step_o)
);

// File: tb/stepper_phase_gen_tb_top.sv
module stepper_phase_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0, dir_i = 1'b1, hold_i = 1'b0, run_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [3:0] coil_o;
  logic       ref_step_o;

  typedef struct { logic [3:0] coil; logic rf; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stepper_phase_gen dut_i (.*);

  task automatic expect_now(input logic [3:0] c, input logic r, input string tag);
    exp_t e;
    e.coil = c; e.rf = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic stp(input logic d, input logic [3:0] c, input logic r, input string tag);
    @(negedge clk); dir_i = d; step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
    expect_now(c, r, tag);
  endtask

  task automatic chk(input logic [3:0] c, input string tag);
    @(negedge clk); @(negedge clk);
    expect_now(c, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; run_i = 1'b0;
    @(negedge clk); expect_now(4'b0000, 1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); expect_now(4'b0000, 1'b0, "R1 after reset");
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (coil_o !== e.coil || ref_step_o !== e.rf) begin
          bad++;
          $display("FAIL %s: coil=%b ref=%b expected coil=%b ref=%b",
                   e.tag, coil_o, ref_step_o, e.coil, e.rf);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    run_i = 1'b1; mode_i = 2'd0;
    stp(1, 4'b0001, 1, "R2 clockwise reference step");
    stp(1, 4'b0010, 0, "R4 cw 1 / R7 single pulse");
    stp(1, 4'b0100, 0, "R4 cw 2");
    stp(1, 4'b1000, 0, "R4 cw 3");
    stp(1, 4'b0001, 0, "R4 cw wrap");
    stp(0, 4'b1000, 0, "R4 ccw wrap");
    @(negedge clk); mode_i = 2'd1;
    chk(4'b1001, "R10 running switch to pair");
    stp(1, 4'b0011, 0, "R5 cw 1");
    stp(1, 4'b0110, 0, "R5 cw 2");
    stp(1, 4'b1100, 0, "R5 cw 3");
    stp(1, 4'b1001, 0, "R5 cw 4");
    stp(0, 4'b1100, 0, "R5 ccw");
    stp(1, 4'b1001, 0, "R5 cw back");
    @(negedge clk); mode_i = 2'd2;
    stp(1, 4'b0001, 0, "R6 cw 0");
    stp(1, 4'b0011, 0, "R6 cw 1");
    stp(1, 4'b0010, 0, "R6 cw 2");
    stp(1, 4'b0110, 0, "R6 cw 3");
    stp(1, 4'b0100, 0, "R6 cw 4");
    stp(1, 4'b1100, 0, "R6 cw 5");
    stp(1, 4'b1000, 0, "R6 cw 6");
    stp(1, 4'b1001, 0, "R6 cw 7");
    stp(1, 4'b0001, 0, "R6 cw wrap");
    stp(0, 4'b1001, 0, "R6 ccw wrap");
    stp(0, 4'b1000, 0, "R6 ccw");
    stp(1, 4'b1001, 0, "R6 cw back");
    @(negedge clk); run_i = 1'b0; hold_i = 1'b0;
    chk(4'b0000, "R8 stopped coils off");
    stp(1, 4'b0000, 0, "R9 step while stopped");
    @(negedge clk); hold_i = 1'b1;
    chk(4'b1001, "R8 stopped hold / R9 unchanged");
    @(negedge clk); run_i = 1'b1;
    stp(1, 4'b0001, 0, "R9 resume from held position");
    stp(1, 4'b0011, 0, "R6 to pair state");
    @(negedge clk); run_i = 1'b0;
    @(negedge clk); mode_i = 2'd0;
    chk(4'b0001, "R10 pair to single-coil");
    @(negedge clk); mode_i = 2'd1;
    chk(4'b0011, "R10 single-coil to pair");
    @(negedge clk); mode_i = 2'd3;
    chk(4'b0001, "R10 mode 3 acts as single-coil");
    do_reset();
    run_i = 1'b1; mode_i = 2'd0; hold_i = 1'b0;
    stp(0, 4'b1000, 1, "R3 R11 ccw reference step");
    stp(0, 4'b0100, 0, "R7 no second pulse");
    do_reset();
    run_i = 1'b1; mode_i = 2'd1;
    stp(0, 4'b1001, 1, "R3 R11 ccw reference in pair mode");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule